// File: doc/BRIEF.md
# Flash ECC Error Status Unit

This unit collects correctable and uncorrectable ECC events from two flash read paths and holds them in sticky status flags. The first path has no checker of its own. An external checker gives it a one-cycle `ext_corr_ev` pulse that says only that a correction happened, not which way the bit flipped. The second path carries a full 72-bit codeword into a local SECDED decoder. That decoder corrects single errors, detects double errors and reports whether the corrected bit was a stored one that should have been zero, or a stored zero that should have been one.

Three sticky flags are kept: error-on-zero, error-on-one and uncorrectable. Software enables the two direction flags with `cfg_zero_en` and `cfg_one_en`. It clears any flag by pulsing its write-one clear input for one cycle.

The decoder holds a per-read classification state that is reloaded on every clock edge. The state is `DK_CLEAN` when no read is presented, or when the syndrome is zero and the parity is even. The state is `DK_SINGLE` when the parity is odd and the syndrome is in range. The state is `DK_MULTI` for every other case of a valid read. Each flag bit has two states, clear and set. It moves from clear to set on a set event, and from set to clear on a clear pulse that has no set event in the same cycle.

Top module: `ecc_status_unit`

## Requirements
- R1: Codeword layout: bit 0 of `rd_code` is the overall even parity over all 72 bits. Bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits. The 64 data bits sit at the remaining positions 3..71 in ascending order, with data bit 0 lowest. The check bit at position 2^j makes the XOR of all positions with index bit j set equal to zero. `cor_valid` is high exactly in the cycle after a cycle with `rd_valid` high. For a clean codeword, `cor_data` holds the data bits in that cycle.
- R2: A single flipped data position is corrected in `cor_data`.
- R3: A single flipped check or parity position (0, or a power of two) counts as correctable. In this case `cor_data` equals the stored data bits.
- R4: For a path-2 single error, the flip is classified by the raw bit read at the faulty position. A raw value of 1 sets `flag_one`, but only if `cfg_one_en` is high. A raw value of 0 sets `flag_zero`, but only if `cfg_zero_en` is high.
- R5: An `ext_corr_ev` pulse sets `flag_zero` when either enable is high. It never sets `flag_one`. It has no effect when both enables are low.
- R6: A path-2 read is uncorrectable in two cases: a nonzero syndrome with even parity, or an odd parity with a syndrome of 72 or more. Such a read sets `flag_dbl` and leaves the direction flags untouched. `cor_data` then holds the raw data bits.
- R7: The flags are sticky. Each one clears only through its own one-cycle clear input, and the other flags are not affected.
- R8: A set and a clear of the same flag in the same cycle leave the flag set.
- R9: A path-1 event and a path-2 event in the same cycle are both applied.
- R10: After reset, all three flags and `cor_valid` are low.
- R11: A path-1 event shows in the flags in the cycle after the pulse. A path-2 event shows in the cycle after `cor_valid`. Enables are sampled in the cycle in which the event is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_zero_en | input | 1 | Enable for the error-on-zero flag |
| cfg_one_en | input | 1 | Enable for the error-on-one flag |
| ext_corr_ev | input | 1 | Path-1 correctable event pulse |
| rd_valid | input | 1 | Path-2 codeword valid |
| rd_code | input | 72 | Path-2 raw codeword |
| clr_zero | input | 1 | Write-one clear of flag_zero |
| clr_one | input | 1 | Write-one clear of flag_one |
| clr_dbl | input | 1 | Write-one clear of flag_dbl |
| cor_valid | output | 1 | Corrected data valid |
| cor_data | output | 64 | Corrected data |
| flag_zero | output | 1 | Sticky error-on-zero flag |
| flag_one | output | 1 | Sticky error-on-one flag |
| flag_dbl | output | 1 | Sticky uncorrectable flag |

## Verification
Codewords are run in several forms: clean words, words with one flipped data bit, words with one flipped check or parity bit, words with two flipped bits, and words with three flipped bits whose syndrome falls outside the word. All-zero data separates the zero-to-one direction from the one-to-zero direction seen with all-ones data, and mixed data checks that the correction lands in the right position. Each direction is tried with its enable on and with it off. Path-1 pulses are applied under each enable combination, alone and together with a path-2 error, to show that path 1 reaches only the zero flag and that both paths are applied together. Directed cases cover stickiness, selective clearing and set-over-clear.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    typedef enum logic [1:0] {
        DK_CLEAN  = 2'd0,
        DK_SINGLE = 2'd1,
        DK_MULTI  = 2'd2
    } dec_kind_e;

    localparam int unsigned FLG_ZERO = 0;
    localparam int unsigned FLG_ONE  = 1;
    localparam int unsigned FLG_DBL  = 2;
    localparam int unsigned FLG_N    = 3;

    // Codeword position of data bit k: the k-th index from 3 upward that is
    // not a power of two.
    function automatic int unsigned ecc_data_pos(input int unsigned k);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 3; p < 1024; p++) begin
            if (((p & (p - 1)) != 0) && (res == 0)) begin
                if (cnt == k) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned P_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_valid,
    input  logic [DATA_W+P_W:0]        rd_code,
    output logic                       cor_valid,
    output logic [DATA_W-1:0]          cor_data,
    output logic                       dec_single,
    output logic                       dec_multi,
    output logic                       dec_dir_one
);
    localparam int unsigned CW_W = DATA_W + P_W + 1;

    logic [P_W-1:0]    syn;
    logic              par;
    dec_kind_e         kind_d, kind_q;
    logic              raw_bit;
    logic [DATA_W-1:0] dat_c;
    logic              dir_q;
    logic [DATA_W-1:0] data_q;

    // Syndrome is the XOR of the indices of all set positions.
    always_comb begin
        syn = '0;
        for (int unsigned i = 1; i < CW_W; i++) begin
            if (rd_code[i]) syn = syn ^ P_W'(i);
        end
        par = ^rd_code;
    end

    always_comb begin
        if (!rd_valid) begin
            kind_d = DK_CLEAN;
        end else if ((syn == '0) && !par) begin
            kind_d = DK_CLEAN;
        end else if (par && (int'(syn) < int'(CW_W))) begin
            kind_d = DK_SINGLE;
        end else begin
            kind_d = DK_MULTI;
        end
        raw_bit = (int'(syn) < int'(CW_W)) ? rd_code[syn] : 1'b0;
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_extract
        localparam int unsigned POS = ecc_data_pos(k);
        assign dat_c[k] = rd_code[POS] ^ ((kind_d == DK_SINGLE) && (int'(syn) == int'(POS)));
    end

    // Per-read classification state, reloaded every edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= DK_CLEAN;
            cor_valid <= 1'b0;
            data_q    <= '0;
            dir_q     <= 1'b0;
        end else begin
            kind_q    <= kind_d;
            cor_valid <= rd_valid;
            if (rd_valid) begin
                data_q <= dat_c;
                dir_q  <= raw_bit;
            end
        end
    end

    always_comb begin
        dec_single  = 1'b0;
        dec_multi   = 1'b0;
        dec_dir_one = 1'b0;
        cor_data    = data_q;
        unique case (kind_q)
            DK_CLEAN:  ;
            DK_SINGLE: begin
                dec_single  = 1'b1;
                dec_dir_one = dir_q;
            end
            DK_MULTI:  dec_multi = 1'b1;
            default:   ;
        endcase
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> cor_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !cor_valid);
    assert_event_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_single || dec_multi) |-> cor_valid);

endmodule

// File: rtl/ecc_sticky_bit.sv
module ecc_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank
    import ecc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_zero,
    input  logic             en_one,
    input  logic             ext_ev,
    input  logic             p2_sgl,
    input  logic             p2_dir_one,
    input  logic             p2_multi,
    input  logic [FLG_N-1:0] clr,
    output logic [FLG_N-1:0] flags
);
    logic [FLG_N-1:0] set_v;

    always_comb begin
        set_v           = '0;
        set_v[FLG_ZERO] = (ext_ev && (en_zero || en_one)) ||
                          (p2_sgl && !p2_dir_one && en_zero);
        set_v[FLG_ONE]  = p2_sgl && p2_dir_one && en_one;
        set_v[FLG_DBL]  = p2_multi;
    end

    for (genvar f = 0; f < FLG_N; f++) begin : g_flag
        ecc_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[f]),
            .clr_i (clr[f]),
            .q     (flags[f])
        );
    end

    assert_one_from_path2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_ONE] && !$past(flags[FLG_ONE])) |-> $past(p2_sgl && p2_dir_one && en_one));
    assert_ext_sets_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ev && (en_zero || en_one)) |=> flags[FLG_ZERO]);
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_multi && clr[FLG_DBL]) |=> flags[FLG_DBL]);
    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[FLG_ONE] && !(p2_sgl && p2_dir_one && en_one)) |=> !flags[FLG_ONE]);
    assert_dir_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_sgl && !p2_dir_one && en_zero) |=> flags[FLG_ZERO]);

endmodule

// File: rtl/ecc_status_unit.sv
module ecc_status_unit
    import ecc_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned P_W    = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_zero_en,
    input  logic                    cfg_one_en,
    input  logic                    ext_corr_ev,
    input  logic                    rd_valid,
    input  logic [DATA_W+P_W:0]     rd_code,
    input  logic                    clr_zero,
    input  logic                    clr_one,
    input  logic                    clr_dbl,
    output logic                    cor_valid,
    output logic [DATA_W-1:0]       cor_data,
    output logic                    flag_zero,
    output logic                    flag_one,
    output logic                    flag_dbl
);
    logic             d_sgl, d_multi, d_dir;
    logic [FLG_N-1:0] clr_v, flg_v;

    ecc_secded_dec #(.DATA_W(DATA_W), .P_W(P_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_valid    (rd_valid),
        .rd_code     (rd_code),
        .cor_valid   (cor_valid),
        .cor_data    (cor_data),
        .dec_single  (d_sgl),
        .dec_multi   (d_multi),
        .dec_dir_one (d_dir)
    );

    always_comb begin
        clr_v           = '0;
        clr_v[FLG_ZERO] = clr_zero;
        clr_v[FLG_ONE]  = clr_one;
        clr_v[FLG_DBL]  = clr_dbl;
    end

    ecc_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_zero    (cfg_zero_en),
        .en_one     (cfg_one_en),
        .ext_ev     (ext_corr_ev),
        .p2_sgl     (d_sgl),
        .p2_dir_one (d_dir),
        .p2_multi   (d_multi),
        .clr        (clr_v),
        .flags      (flg_v)
    );

    assign flag_zero = flg_v[FLG_ZERO];
    assign flag_one  = flg_v[FLG_ONE];
    assign flag_dbl  = flg_v[FLG_DBL];

    assert_multi_no_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_multi && !flag_one && !clr_one) |=> !flag_one);

endmodule

// File: tb/ecc_status_unit_tb_top.sv
`timescale 1ns/1ps
module ecc_status_unit_tb_top;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  e1;
        logic [7:0]  e2;
        logic        enz;
        logic        eno;
        logic        ext;
    } vec_t;

    localparam logic [7:0] NONE = 8'hFF;
    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{64'h0123_4567_89AB_CDEF, NONE,  NONE,  1'b1, 1'b1, 1'b0}, // R1 clean
        '{64'h0123_4567_89AB_CDEF, 8'd5,  NONE,  1'b1, 1'b1, 1'b0}, // R2
        '{64'h0,                   8'd3,  NONE,  1'b0, 1'b1, 1'b0}, // R4 one
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'd3,  NONE,  1'b1, 1'b0, 1'b0}, // R4 zero
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'd3,  NONE,  1'b0, 1'b1, 1'b0}, // R4 gated
        '{64'h0123_4567_89AB_CDEF, 8'd10, 8'd20, 1'b1, 1'b1, 1'b0}, // R6
        '{64'h0,                   8'd0,  NONE,  1'b0, 1'b1, 1'b0}, // R3 parity
        '{64'hA5A5_5A5A_F00F_0FF0, NONE,  NONE,  1'b0, 1'b1, 1'b1}, // R5
        '{64'hA5A5_5A5A_F00F_0FF0, NONE,  NONE,  1'b0, 1'b0, 1'b1}, // R5 none
        '{64'h0,                   8'd71, NONE,  1'b0, 1'b1, 1'b1}, // R9
        '{64'h0,                   8'd64, NONE,  1'b1, 1'b1, 1'b0}, // R3 check
        '{64'hDEAD_BEEF_CAFE_F00D, 8'd70, NONE,  1'b1, 1'b1, 1'b0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_zero_en = 1'b0, cfg_one_en = 1'b0, ext_corr_ev = 1'b0;
    logic        rd_valid = 1'b0;
    logic [71:0] rd_code = '0;
    logic        clr_zero = 1'b0, clr_one = 1'b0, clr_dbl = 1'b0;
    logic        cor_valid, flag_zero, flag_one, flag_dbl;
    logic [63:0] cor_data;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ecc_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_zero_en(cfg_zero_en), .cfg_one_en(cfg_one_en),
        .ext_corr_ev(ext_corr_ev), .rd_valid(rd_valid), .rd_code(rd_code),
        .clr_zero(clr_zero), .clr_one(clr_one), .clr_dbl(clr_dbl),
        .cor_valid(cor_valid), .cor_data(cor_data),
        .flag_zero(flag_zero), .flag_one(flag_one), .flag_dbl(flag_dbl)
    );

    function automatic logic [71:0] enc(input logic [63:0] d);
        logic [71:0] c;
        int k;
        logic x;
        c = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            x = 1'b0;
            for (int p = 1; p < 72; p++) begin
                if (((p >> j) & 1) == 1 && p != (1 << j)) x = x ^ c[p];
            end
            c[1 << j] = x;
        end
        c[0] = ^c[71:1];
        return c;
    endfunction

    function automatic logic [63:0] pick(input logic [71:0] c);
        logic [63:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_zero = 1'b1; clr_one = 1'b1; clr_dbl = 1'b1;
        @(negedge clk);
        clr_zero = 1'b0; clr_one = 1'b0; clr_dbl = 1'b0;
    endtask

    // Applies one read, checks data one cycle later and flags one more later.
    task automatic run_read(input string req, input logic [71:0] raw, input logic enz,
                            input logic eno, input logic ext, input logic [63:0] exp_d,
                            input logic [2:0] exp_f);
        cfg_zero_en = enz; cfg_one_en = eno;
        rd_code = raw; rd_valid = 1'b1; ext_corr_ev = ext;
        @(negedge clk);
        rd_valid = 1'b0; ext_corr_ev = 1'b0;
        chk({req, " cor_valid"}, {63'd0, cor_valid}, 64'd1);
        chk({req, " cor_data"}, cor_data, exp_d);
        @(negedge clk);
        chk({req, " flags(dbl,one,zero)"}, {61'd0, flag_dbl, flag_one, flag_zero},
            {61'd0, exp_f});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [71:0] cw, raw;
        int nflip;
        logic dir_one;
        logic [2:0] ef;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 flags at reset", {61'd0, flag_dbl, flag_one, flag_zero}, 64'd0);
        chk("R10 cor_valid at reset", {63'd0, cor_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            clear_all();
            cw = enc(VT[v].data);
            raw = cw;
            nflip = 0;
            dir_one = 1'b0;
            if (VT[v].e1 != NONE) begin
                raw[VT[v].e1] = ~raw[VT[v].e1];
                dir_one = raw[VT[v].e1];
                nflip++;
            end
            if (VT[v].e2 != NONE) begin
                raw[VT[v].e2] = ~raw[VT[v].e2];
                nflip++;
            end
            ef = '0;
            ef[0] = VT[v].ext && (VT[v].enz || VT[v].eno);
            if (nflip == 1) begin
                if (dir_one) ef[1] = VT[v].eno;
                else ef[0] = ef[0] || VT[v].enz;
            end
            if (nflip == 2) ef[2] = 1'b1;
            run_read($sformatf("R1/R2/R3/R4/R5/R6/R9/R11 vector %0d", v), raw,
                     VT[v].enz, VT[v].eno, VT[v].ext,
                     (nflip == 2) ? pick(raw) : VT[v].data, ef);
        end

        // R1 valid drops after one cycle
        chk("R1 cor_valid low after pulse", {63'd0, cor_valid}, 64'd0);

        // R6 three flips with out-of-range syndrome (8^16^64 = 88)
        clear_all();
        cw = enc(64'h1357_9BDF_2468_ACE0);
        raw = cw ^ ((72'd1 << 8) | (72'd1 << 16) | (72'd1 << 64));
        run_read("R6 out-of-range syndrome", raw, 1'b1, 1'b1, 1'b0, pick(raw), 3'b100);

        // R7 stickiness and selective clear
        clear_all();
        raw = enc(64'h0) ^ (72'd1 << 3);
        run_read("R9 both paths", raw, 1'b1, 1'b1, 1'b1, 64'h0, 3'b011);
        repeat (3) @(negedge clk);
        chk("R7 flags stay set", {61'd0, flag_dbl, flag_one, flag_zero}, 64'd3);
        clr_one = 1'b1;
        @(negedge clk);
        clr_one = 1'b0;
        chk("R7 clr_one clears only one", {61'd0, flag_dbl, flag_one, flag_zero}, 64'd1);
        clr_zero = 1'b1;
        @(negedge clk);
        clr_zero = 1'b0;
        chk("R7 clr_zero clears zero", {61'd0, flag_dbl, flag_one, flag_zero}, 64'd0);

        // R8 set beats clear, path 1
        cfg_zero_en = 1'b1; cfg_one_en = 1'b0;
        ext_corr_ev = 1'b1; clr_zero = 1'b1;
        @(negedge clk);
        ext_corr_ev = 1'b0; clr_zero = 1'b0;
        chk("R8 path-1 set over clear", {63'd0, flag_zero}, 64'd1);

        // R8 set beats clear, path 2 uncorrectable
        raw = enc(64'h55) ^ ((72'd1 << 9) | (72'd1 << 11));
        rd_code = raw; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0; clr_dbl = 1'b1;
        @(negedge clk);
        clr_dbl = 1'b0;
        chk("R8 path-2 set over clear", {63'd0, flag_dbl}, 64'd1);

        // R5 path 1 with both enables off leaves flags
        clear_all();
        cfg_zero_en = 1'b0; cfg_one_en = 1'b0;
        ext_corr_ev = 1'b1;
        @(negedge clk);
        ext_corr_ev = 1'b0;
        @(negedge clk);
        chk("R5 disabled path-1 ignored", {61'd0, flag_dbl, flag_one, flag_zero}, 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule